// File: doc/BRIEF.md
# Power-Down Freeze Controller

This block sits between a logic core and its pins and freezes the core's whole external interface while a power-down request is present. Two pins of the input set can each be configured to act as a sleep request. When an enabled request pin goes high, the controller synchronises the request to the system clock. It then captures the live output values, output enables and input values on a single clock edge, and on that same edge it stops the core clock through a clock-enable output. From then on the core sees a frozen input set, and the pins see the frozen output data and enables.

Outputs whose enable was low at entry stay undriven for the whole sleep period. A pin configured as a sleep request never feeds the core as a logic input; the core reads it as zero in both normal and frozen operation. When every enabled request pin is low again, the controller leaves the frozen state after the same synchroniser delay. Outputs and inputs then pass straight through again and the core clock restarts. A status output reports the frozen state.

Top module: `pwrdn_hold_ctrl`

## Requirements
- R1: The sleep request is `(pin_in[PD_A_IDX] & pd_en[0]) | (pin_in[PD_B_IDX] & pd_en[1])`. A request that becomes true before clock edge 1 makes `pd_active` high after edge 3 and not before: two synchroniser flops, then the state flop.
- R2: A request pin whose enable bit is 0 never causes `pd_active` to rise, whatever its level.
- R3: While `pd_active` is high, `pad_out` and `pad_oe` equal the `core_out` and `core_oe` values present just before the edge on which `pd_active` rose. A bit of `pad_oe` that was 0 at entry stays 0.
- R4: While `pd_active` is high, `core_in` keeps the value it had just before entry, whatever `pin_in` does.
- R5: The `core_in` bit at `PD_A_IDX` reads 0 whenever `pd_en[0]` is 1. The bit at `PD_B_IDX` reads 0 whenever `pd_en[1]` is 1. This holds in normal and frozen operation.
- R6: `core_clk_en` is 0 exactly while `pd_active` is 1.
- R7: After the request becomes false before edge 1, `pd_active` stays high after edge 2 and is low after edge 3. Pass-through then resumes.
- R8: During and after reset, `pd_active` is 0, `core_clk_en` is 1 and the block passes signals through.
- R9: While `pd_active` is 0, `pad_out = core_out` and `pad_oe = core_oe` combinationally. `core_in` equals `pin_in` with the enabled request bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pd_en | input | 2 | Bit 0 enables request pin A, bit 1 enables request pin B |
| pin_in | input | N_IN | Raw input pin values, including both candidate request pins |
| core_out | input | N_IO | Output data from the core |
| core_oe | input | N_IO | Output enables from the core, 1 drives the pin |
| core_in | output | N_IN | Gated input values presented to the core |
| pad_out | output | N_IO | Output data towards the pins, frozen while asleep |
| pad_oe | output | N_IO | Output enables towards the pins, frozen while asleep |
| core_clk_en | output | 1 | Clock enable for the core clock gate |
| pd_active | output | 1 | High while the interface is frozen |

## Verification
The assertions assume that `pd_en` stays constant for the whole sleep period. They also assume that the core holds its outputs steady around the capture edge only as far as the comparison with the previous cycle requires. The bench changes `pd_en` only while the block is awake and the request pins are low. It changes pins and core values only at the falling clock edge, so the capture edge always sees settled values. The bench drives a request pin high and holds it there until it has checked entry. It changes the other pins and the core values while frozen to show that they have no effect.

// File: rtl/pdh_pkg.sv
package pdh_pkg;
  // number of candidate sleep-request pins
  localparam int unsigned PD_SLOTS = 2;
  typedef logic [PD_SLOTS-1:0] pd_en_t;

  typedef enum logic {
    PDH_AWAKE  = 1'b0,
    PDH_FROZEN = 1'b1
  } pdh_state_e;
endpackage

// File: rtl/pdh_sync.sv
module pdh_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_nx;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sr_nx = d;
    end else begin : g_many
      always_comb sr_nx = {sr_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= '0;
    else         sr_q <= sr_nx;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/pdh_ctrl.sv
module pdh_ctrl
  import pdh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  output logic cap_en,
  output logic frozen
);
  pdh_state_e state_q, state_nx;

  always_comb begin
    state_nx = state_q;
    case (state_q)
      PDH_AWAKE:  if (req_s)  state_nx = PDH_FROZEN;
      PDH_FROZEN: if (!req_s) state_nx = PDH_AWAKE;
      default:    state_nx = PDH_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PDH_AWAKE;
    else        state_q <= state_nx;
  end

  assign frozen = (state_q == PDH_FROZEN);
  assign cap_en = (state_q == PDH_AWAKE) && req_s;

  // R1
  enter_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> $past(req_s));
  // R7
  leave_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frozen) |-> !$past(req_s));
endmodule

// File: rtl/pdh_hold.sv
module pdh_hold #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         frozen,
  input  logic [W-1:0] live,
  output logic [W-1:0] q
);
  logic [W-1:0] held_q, held_nx;

  always_comb held_nx = cap_en ? live : held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_nx;
  end

  assign q = frozen ? held_q : live;

  // R3
  capture_at_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> (q == $past(live)));
  // R4
  steady_while_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && $past(frozen)) |-> $stable(q));
endmodule

// File: rtl/pwrdn_hold_ctrl.sv
module pwrdn_hold_ctrl
  import pdh_pkg::*;
#(
  parameter int unsigned N_IN        = 6,
  parameter int unsigned N_IO        = 4,
  parameter int unsigned PD_A_IDX    = 4,
  parameter int unsigned PD_B_IDX    = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      pd_en,
  input  logic [N_IN-1:0] pin_in,
  input  logic [N_IO-1:0] core_out,
  input  logic [N_IO-1:0] core_oe,
  output logic [N_IN-1:0] core_in,
  output logic [N_IO-1:0] pad_out,
  output logic [N_IO-1:0] pad_oe,
  output logic            core_clk_en,
  output logic            pd_active
);
  localparam int unsigned IO_W = 2 * N_IO;

  logic            rst_i_n;
  logic            req_raw, req_s;
  logic            cap_en, frozen;
  logic [N_IN-1:0] in_mask, in_live;
  logic [IO_W-1:0] io_live, io_q;
  pd_en_t          en_i;

  assign en_i = pd_en;

  // reset: asserted asynchronously, released on the clock
  pdh_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .d(1'b1), .q(rst_i_n)
  );

  assign req_raw = (pin_in[PD_A_IDX] & en_i[0]) | (pin_in[PD_B_IDX] & en_i[1]);

  pdh_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .arst_n(rst_i_n), .d(req_raw), .q(req_s)
  );

  pdh_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .req_s(req_s), .cap_en(cap_en), .frozen(frozen)
  );

  // request pins in use are taken out of the logic input set
  for (genvar i = 0; i < N_IN; i++) begin : g_mask
    localparam bit IS_A = (i == PD_A_IDX);
    localparam bit IS_B = (i == PD_B_IDX);
    assign in_mask[i] = !((IS_A && en_i[0]) || (IS_B && en_i[1]));
  end

  assign in_live = pin_in & in_mask;

  pdh_hold #(.W(N_IN)) u_hold_in (
    .clk(clk), .rst_n(rst_i_n), .cap_en(cap_en), .frozen(frozen),
    .live(in_live), .q(core_in)
  );

  assign io_live = {core_oe, core_out};

  pdh_hold #(.W(IO_W)) u_hold_io (
    .clk(clk), .rst_n(rst_i_n), .cap_en(cap_en), .frozen(frozen),
    .live(io_live), .q(io_q)
  );

  assign pad_out     = io_q[N_IO-1:0];
  assign pad_oe      = io_q[IO_W-1:N_IO];
  assign core_clk_en = !frozen;
  assign pd_active   = frozen;

  // R5
  pd_a_masked_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (en_i[0] && !pd_active) |-> (core_in[PD_A_IDX] == 1'b0));
  // R5
  pd_b_masked_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (en_i[1] && !pd_active) |-> (core_in[PD_B_IDX] == 1'b0));
  // R2
  no_wake_disabled_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pd_en == 2'b00 && $past(pd_en) == 2'b00) |=> !$rose(pd_active));
endmodule

// File: tb/pwrdn_hold_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwrdn_hold_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] pd_en;
  logic [5:0] pin_in;
  logic [3:0] core_out, core_oe;
  logic [5:0] core_in;
  logic [3:0] pad_out, pad_oe;
  logic       core_clk_en, pd_active;
  int         n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  pwrdn_hold_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pd_en(pd_en), .pin_in(pin_in),
    .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .core_clk_en(core_clk_en),
    .pd_active(pd_active)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] msk(input logic [1:0] en);
    return 6'b111111 & ~{en[1], en[0], 4'b0000};
  endfunction

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_pd(input logic [1:0] en, input logic [1:0] trig, input logic [3:0] p);
    logic [5:0] frz;
    logic       will;
    pd_en = en; pin_in = {2'b00, p}; core_out = p; core_oe = p ^ 4'hA;
    edges(2);
    pin_in[5:4] = trig;
    frz  = pin_in & msk(en);
    will = |(trig & en);
    edges(2);
    chk("R1 no early entry", {7'd0, pd_active}, 8'd0);
    edges(1);
    if (!will) begin
      edges(3);
      chk("R2 disabled pin ignored", {7'd0, pd_active}, 8'd0);
      chk("R9 pass-through", {pad_oe, pad_out}, {p ^ 4'hA, p});
      pin_in[5:4] = 2'b00;
      edges(1);
      return;
    end
    chk("R1 entry", {7'd0, pd_active}, 8'd1);
    chk("R6 clock stopped", {7'd0, core_clk_en}, 8'd0);
    core_out = ~p; core_oe = ~(p ^ 4'hA); pin_in[3:0] = ~p;
    if (!en[0]) pin_in[4] = ~pin_in[4];
    #1;
    chk("R3 held outputs", {pad_oe, pad_out}, {p ^ 4'hA, p});
    chk("R4 held inputs", {2'b00, core_in}, {2'b00, frz});
    if (en[0] && trig[0]) chk("R5 pin A masked", {7'd0, core_in[4]}, 8'd0);
    if (en[1] && trig[1]) chk("R5 pin B masked", {7'd0, core_in[5]}, 8'd0);
    edges(3);
    chk("R3 outputs still held", {pad_oe, pad_out}, {p ^ 4'hA, p});
    chk("R4 inputs still held", {2'b00, core_in}, {2'b00, frz});
    pin_in[5:4] = 2'b00;
    edges(2);
    chk("R7 still frozen", {7'd0, pd_active}, 8'd1);
    edges(1);
    chk("R7 exit", {6'd0, core_clk_en, pd_active}, 8'b10);
    chk("R7 pass-through resumed", {pad_oe, pad_out}, {~(p ^ 4'hA), ~p});
    chk("R7 inputs live", {2'b00, core_in}, {2'b00, pin_in & msk(en)});
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pd_en = 2'b00; pin_in = '0; core_out = 4'h5; core_oe = 4'h3;
    edges(3);
    chk("R8 reset state", {6'd0, core_clk_en, pd_active}, 8'b10);
    chk("R8 reset pass-through", {pad_oe, pad_out}, 8'h35);
    rst_n = 1'b1;
    edges(4);
    chk("R8 after reset", {6'd0, core_clk_en, pd_active}, 8'b10);

    // normal-mode sweep over enables, outputs, enables and inputs
    for (int e = 0; e < 4; e++) begin
      for (int v = 0; v < 256; v++) begin
        pd_en = e[1:0]; core_out = v[3:0]; core_oe = v[7:4];
        pin_in[3:0] = v[3:0] ^ v[7:4];
        pin_in[4] = e[0] ? 1'b0 : v[6];
        pin_in[5] = e[1] ? 1'b0 : v[7];
        #1;
        chk("R9 out", {4'd0, pad_out}, {4'd0, v[3:0]});
        chk("R9 oe", {4'd0, pad_oe}, {4'd0, v[7:4]});
        chk("R9 R5 in", {2'b00, core_in}, {2'b00, pin_in & msk(e[1:0])});
        chk("R2 R6 awake", {6'd0, core_clk_en, pd_active}, 8'b10);
        edges(1);
      end
    end
    pin_in = '0;
    edges(4);

    // entry/exit sweep over enable, trigger pin and captured pattern
    for (int e = 0; e < 4; e++)
      for (int t = 1; t < 4; t++)
        for (int p = 0; p < 16; p++)
          run_pd(e[1:0], t[1:0], p[3:0]);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule